// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt sources into one interrupt line for a CPU. Every source owns a small programmable priority. A source that goes high is captured in a pending-request register and stays there until it is serviced. The arbiter looks for the strongest pending source and drives the CPU line only when that source outranks everything the CPU is already handling. An in-service register records which sources the CPU has accepted and not yet finished, so higher-priority work can interrupt lower-priority handlers.

Software works through a small register window. A destructive read of the acknowledge register returns the winning vector, moves the source from pending to in-service and clears its request. A second address returns the same vector with no side effect, for debugging. Once an enable bit is set, a write to the acknowledge register also acknowledges. An end-of-interrupt write retires the strongest in-service source. Software also has a per-source mask, a global mask, a priority register and a fixed identification word. An external debug-acknowledge pin passes through a two-flop synchronizer and, when software enables it, forces the global mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending, in-service, mask, control and priority registers read zero and `irq_out` is low.
- R2: A read of the acknowledge register (address 0) returns the vector of the winning source, which is its index plus one. The same read sets that source's in-service bit and clears its pending bit.
- R3: Among eligible pending sources, a larger priority value wins. When priorities are equal, the lower source index wins.
- R4: A read of the debug vector register (address 1) returns the same vector an acknowledge would return and changes neither pending nor in-service state.
- R5: An acknowledge read with no eligible source returns vector 0 and leaves all state unchanged.
- R6: While any in-service bit is set, a pending source is eligible, and can raise `irq_out` or be acknowledged, only if its priority is strictly greater than that of the strongest in-service source.
- R7: A write to the end-of-interrupt register (address 2) clears only the in-service bit of the strongest in-service source. Once the last in-service bit is clear, lower-priority sources that stayed pending are forwarded again.
- R8: A write to the acknowledge register acknowledges exactly like a read only when control bit 1 is set. Control bit 1 is clear after reset, and while it is clear such a write has no effect.
- R9: The pin `dbg_ack_in` takes effect two clock edges after it rises, through a two-flop synchronizer. It forces the global mask only when control bit 2 is set.
- R10: The per-source mask (address 3, 1 = masked) excludes masked sources from arbitration. The global mask (control bit 0 at address 4) holds `irq_out` low. Neither mask stops requests from being latched into the pending register (address 6).
- R11: The priority register (address 5) holds field `PRIO_W` bits wide for each source, with source i at bits [i*PRIO_W +: PRIO_W]. A write to it is ignored while any in-service bit (address 7) is set.
- R12: The identification register (address 8) always reads `ID_VALUE`.
- R13: A source that pulses high for a single cycle stays pending after its input falls, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_SRC | Level interrupt requests, synchronous to clk |
| dbg_ack_in | input | 1 | Asynchronous debug-acknowledge request |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address and state |
| irq_out | output | 1 | Interrupt line to the CPU |

## Verification
On every cycle the assertions check four things: an acknowledge adds exactly one in-service bit, an end-of-interrupt removes exactly one, an empty acknowledge, a debug read or a disabled write acknowledge leaves the in-service set untouched, and priority writes during service do not stick. The line is also checked to stay low while the global mask is set. Other behaviour only the bench can show, by comparing against its own model over directed and random traffic. That covers which vector wins, including ties and nesting, that lower-priority work is forwarded after the last end-of-interrupt, the two-edge latency of the debug pin, and requests latched behind masks.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and control-register layout for the
// nested priority interrupt controller. No assumptions beyond a 4-bit
// register address.
package irqc_pkg;

    typedef enum logic [3:0] {
        REG_ACK   = 4'd0,
        REG_PEEK  = 4'd1,
        REG_EOI   = 4'd2,
        REG_MASK  = 4'd3,
        REG_CTRL  = 4'd4,
        REG_PRIO  = 4'd5,
        REG_PEND  = 4'd6,
        REG_INSRV = 4'd7,
        REG_ID    = 4'd8
    } irqc_reg_e;

    typedef struct packed {
        logic dbg_en;   // bit 2: debug pin may force the global mask
        logic wack_en;  // bit 1: writes to the acknowledge register acknowledge
        logic gmask;    // bit 0: global mask of the CPU line
    } irqc_ctrl_t;

endpackage

// File: rtl/irqc_sync2.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level, not a pulse that is shorter than a clock.
module irqc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_prio_pick.sv
`timescale 1ns/1ps
// Combinational search for the strongest valid entry. A larger priority
// value wins. On equal priority the lower index wins, because a later
// entry must be strictly greater to replace the current best.
module irqc_prio_pick #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    valid,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   prio
);
    // Linear scan from index 0 upward, keeping the best so far.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!found || prio_flat[i*PW +: PW] > prio)) begin
                found = 1'b1;
                idx   = IW'(i);
                prio  = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Nested priority interrupt controller, top level.
// Latches level requests, arbitrates them by programmable priority and
// tracks nested servicing in an in-service register. It drives one CPU
// interrupt line and exposes a small register window.
// Assumes: irq_in is synchronous to clk; only one of bus_rd/bus_wr is
// high in a cycle; bus_rdata is valid during the cycle of the strobe.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          N_SRC    = 8,
    parameter int          PRIO_W   = 3,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h0001_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              dbg_ack_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int VEC_W     = $clog2(N_SRC + 1);
    localparam int PRIO_BITS = N_SRC * PRIO_W;
    localparam int CTRL_W    = $bits(irqc_ctrl_t);

    logic [N_SRC-1:0]     req_q, insrv_q, mask_q;
    logic [PRIO_BITS-1:0] prio_q;
    irqc_ctrl_t           ctrl_q;

    logic                 pend_found, isr_found, pend_ok;
    logic [IDX_W-1:0]     pend_idx, isr_idx;
    logic [PRIO_W-1:0]    pend_prio, isr_prio;
    logic                 dbg_sync, gmask_eff;
    logic                 ack_req, do_ack, do_eoi;
    logic [N_SRC-1:0]     ack_onehot, eoi_onehot;
    logic [VEC_W-1:0]     vector;

    wire unused_wdata_bits = ^bus_wdata[DATA_W-1:PRIO_BITS];

    // Strongest unmasked pending request.
    irqc_prio_pick #(.N(N_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_pend (
        .valid     (req_q & ~mask_q),
        .prio_flat (prio_q),
        .found     (pend_found),
        .idx       (pend_idx),
        .prio      (pend_prio)
    );

    // Strongest source currently in service.
    irqc_prio_pick #(.N(N_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_isr (
        .valid     (insrv_q),
        .prio_flat (prio_q),
        .found     (isr_found),
        .idx       (isr_idx),
        .prio      (isr_prio)
    );

    // Debug-acknowledge pin crosses into the clock domain.
    irqc_sync2 #(.STAGES(2)) u_dbg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (dbg_ack_in),
        .q_out (dbg_sync)
    );

    // Eligibility: pending winner must strictly outrank the active handler.
    always_comb begin
        pend_ok = pend_found && (!isr_found || (pend_prio > isr_prio));
        vector  = pend_ok ? VEC_W'(pend_idx) + VEC_W'(1) : '0;
    end

    // Command decode for acknowledge and end-of-interrupt.
    always_comb begin
        ack_req    = (bus_rd && bus_addr == REG_ACK)
                  || (bus_wr && bus_addr == REG_ACK && ctrl_q.wack_en);
        do_ack     = ack_req && pend_ok;
        do_eoi     = bus_wr && bus_addr == REG_EOI && isr_found;
        ack_onehot = do_ack ? (N_SRC'(1) << pend_idx) : '0;
        eoi_onehot = do_eoi ? (N_SRC'(1) << isr_idx)  : '0;
    end

    // Request latch: inputs set bits, acknowledge clears the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q | irq_in) & ~ack_onehot;
    end

    // In-service register: acknowledge sets, end-of-interrupt clears.
    always_ff @(posedge clk) begin
        if (!rst_n) insrv_q <= '0;
        else        insrv_q <= (insrv_q | ack_onehot) & ~eoi_onehot;
    end

    // Mask and control registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == REG_MASK) mask_q <= bus_wdata[N_SRC-1:0];
            if (bus_addr == REG_CTRL) ctrl_q <= irqc_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Priority register, frozen while any source is in service.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= '0;
        else if (bus_wr && bus_addr == REG_PRIO && insrv_q == '0)
            prio_q <= bus_wdata[PRIO_BITS-1:0];
    end

    // CPU line: eligible request not held back by the effective global mask.
    always_comb begin
        gmask_eff = ctrl_q.gmask | (ctrl_q.dbg_en & dbg_sync);
        irq_out   = pend_ok & ~gmask_eff;
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            REG_ACK, REG_PEEK: bus_rdata = DATA_W'(vector);
            REG_MASK:          bus_rdata = DATA_W'(mask_q);
            REG_CTRL:          bus_rdata = DATA_W'(ctrl_q);
            REG_PRIO:          bus_rdata = DATA_W'(prio_q);
            REG_PEND:          bus_rdata = DATA_W'(req_q);
            REG_INSRV:         bus_rdata = DATA_W'(insrv_q);
            REG_ID:            bus_rdata = DATA_W'(ID_VALUE);
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Assertion checker for prio_irq_ctrl, attached with bind.
// Observes the bus, the CPU line and the in-service and priority state.
module irqc_checker #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_rd,
    input logic                     bus_wr,
    input logic [3:0]               bus_addr,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic                     irq_out,
    input logic [N_SRC-1:0]         insrv_q,
    input logic [N_SRC*PRIO_W-1:0]  prio_q,
    input logic                     gmask_cfg,
    input logic                     wack_en
);
    import irqc_pkg::*;

    // R2: a successful acknowledge read adds exactly one in-service bit.
    assert_ack_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_ACK && bus_rdata != '0)
        |=> $countones(insrv_q) == $countones($past(insrv_q)) + 1);

    // R4: a debug vector read leaves the in-service set alone.
    assert_peek_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_PEEK) |=> $stable(insrv_q));

    // R5: an empty acknowledge changes nothing.
    assert_empty_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_ACK && bus_rdata == '0) |=> $stable(insrv_q));

    // R7: end-of-interrupt retires exactly one in-service bit.
    assert_eoi_clears_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_EOI && insrv_q != '0)
        |=> $countones(insrv_q) == $countones($past(insrv_q)) - 1);

    // R8: write acknowledge is inert while disabled.
    assert_wack_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ACK && !wack_en) |=> $stable(insrv_q));

    // R10: the global mask keeps the CPU line low.
    assert_gmask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_cfg |-> !irq_out);

    // R11: priorities cannot change during service.
    assert_prio_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_PRIO && insrv_q != '0) |=> $stable(prio_q));
endmodule

bind prio_irq_ctrl irqc_checker #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .insrv_q   (insrv_q),
    .prio_q    (prio_q),
    .gmask_cfg (ctrl_q.gmask),
    .wack_en   (ctrl_q.wack_en)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners followed by seeded random traffic,
// all compared against a behavioural model kept in this file.
module prio_irq_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 8;
    localparam int          PW         = 3;
    localparam logic [31:0] IDV        = 32'h0001_0400;
    localparam logic [3:0]  A_ACK = 0, A_PEEK = 1, A_EOI = 2, A_MASK = 3,
                            A_CTRL = 4, A_PRIO = 5, A_PEND = 6, A_INSRV = 7, A_ID = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        dbg_ack_in = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    // model state
    logic [N-1:0]    m_req = '0, m_isr = '0, m_mask = '0;
    logic [N*PW-1:0] m_prio = '0;
    logic            m_gm = 0, m_wack = 0, m_den = 0, m_s1 = 0, m_s2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N), .PRIO_W(PW), .DATA_W(32), .ID_VALUE(IDV)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dbg_ack_in(dbg_ack_in),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic int pick(logic [N-1:0] v);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (v[i] && (best < 0 || m_prio[i*PW +: PW] > m_prio[best*PW +: PW]))
                best = i;
        return best;
    endfunction

    function automatic int elig();
        int p = pick(m_req & ~m_mask);
        int h = pick(m_isr);
        if (p < 0) return -1;
        if (h >= 0 && m_prio[p*PW +: PW] <= m_prio[h*PW +: PW]) return -1;
        return p;
    endfunction

    function automatic logic exp_irq();
        return (elig() >= 0) && !(m_gm || (m_den && m_s2));
    endfunction

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        int e = elig();
        case (a)
            A_ACK, A_PEEK: return (e >= 0) ? 32'(e + 1) : 32'd0;
            A_MASK:  return 32'(m_mask);
            A_CTRL:  return {29'd0, m_den, m_wack, m_gm};
            A_PRIO:  return 32'(m_prio);
            A_PEND:  return 32'(m_req);
            A_INSRV: return 32'(m_isr);
            A_ID:    return IDV;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: check the line, drive, check read data, clock, update model.
    task automatic op(input logic rd, input logic wr, input logic [3:0] a,
                      input logic [31:0] wd, input logic [N-1:0] irq,
                      input logic dbg, input string tag);
        int e, h;
        logic [N-1:0] clr;
        @(negedge clk);
        chk(32'(irq_out), 32'(exp_irq()), {tag, " irq_out"});
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        irq_in = irq; dbg_ack_in = dbg;
        #1;
        if (rd) chk(bus_rdata, exp_rd(a), tag);
        @(posedge clk);
        e = elig(); h = pick(m_isr); clr = '0;
        if (((rd && a == A_ACK) || (wr && a == A_ACK && m_wack)) && e >= 0) clr[e] = 1'b1;
        if (wr && a == A_PRIO && m_isr == '0) m_prio = wd[N*PW-1:0];
        if (wr && a == A_EOI && h >= 0) m_isr[h] = 1'b0;
        if (wr && a == A_MASK) m_mask = wd[N-1:0];
        if (wr && a == A_CTRL) begin m_gm = wd[0]; m_wack = wd[1]; m_den = wd[2]; end
        m_isr = m_isr | clr;
        m_req = (m_req | irq) & ~clr;
        m_s2 = m_s1; m_s1 = dbg;
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag);
        op(1, 0, a, 0, '0, dbg_ack_in, tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input string tag);
        op(0, 1, a, d, '0, dbg_ack_in, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 identification
        rd_reg(A_PEND, "R1 pending"); rd_reg(A_INSRV, "R1 in-service");
        rd_reg(A_CTRL, "R1 control"); rd_reg(A_MASK, "R1 mask");
        rd_reg(A_PRIO, "R1 priority"); rd_reg(A_ID, "R12 id");

        // priorities: src2=5 src5=3 src6=5 src7=7
        wr_reg(A_PRIO, (32'd7 << 21) | (32'd5 << 18) | (32'd3 << 15) | (32'd5 << 6), "R11 set");
        rd_reg(A_PRIO, "R11 readback");

        // R13 single-cycle pulses stay latched
        op(0, 0, A_PEND, 0, 8'h64, 0, "R13 pulse");
        rd_reg(A_PEND, "R13 latched");
        // R3 tie between src2 and src6, R4 peek has no side effect
        rd_reg(A_PEEK, "R3 tie lower index");
        rd_reg(A_PEEK, "R4 peek repeat");
        rd_reg(A_PEND, "R4 pending kept");
        // R2 acknowledge
        rd_reg(A_ACK, "R2 ack vector");
        rd_reg(A_INSRV, "R2 in-service set"); rd_reg(A_PEND, "R2 request cleared");
        // R6 equal priority src6 is blocked; R5 empty ack
        rd_reg(A_PEEK, "R6 equal blocked");
        rd_reg(A_ACK, "R5 empty ack"); rd_reg(A_INSRV, "R5 no change");
        // R11 priority frozen
        wr_reg(A_PRIO, 32'hFFFFFF, "R11 frozen write"); rd_reg(A_PRIO, "R11 frozen");
        // R6 nesting by src7, R7 eoi order and forwarding
        op(0, 0, A_PEND, 0, 8'h80, 0, "R6 raise src7");
        rd_reg(A_ACK, "R6 nested ack"); rd_reg(A_INSRV, "R6 nested set");
        wr_reg(A_EOI, 0, "R7 eoi top"); rd_reg(A_INSRV, "R7 top cleared");
        wr_reg(A_EOI, 0, "R7 eoi last"); rd_reg(A_PEEK, "R7 forwarded");
        rd_reg(A_ACK, "R7 ack src6"); wr_reg(A_EOI, 0, "R7 eoi");
        rd_reg(A_ACK, "R7 ack src5"); wr_reg(A_EOI, 0, "R7 eoi");
        // R10 masks
        wr_reg(A_MASK, 32'hFF, "R10 mask all");
        op(0, 0, A_PEND, 0, 8'h02, 0, "R10 raise src1");
        rd_reg(A_PEND, "R10 latched under mask"); rd_reg(A_PEEK, "R10 masked peek");
        wr_reg(A_MASK, 0, "R10 unmask"); wr_reg(A_CTRL, 32'h1, "R10 global mask");
        rd_reg(A_PEND, "R10 global holds line");
        wr_reg(A_CTRL, 0, "R10 global off"); rd_reg(A_PEND, "R10 line back");
        // R8 write acknowledge
        wr_reg(A_ACK, 0, "R8 wack disabled"); rd_reg(A_INSRV, "R8 no effect");
        wr_reg(A_CTRL, 32'h2, "R8 enable"); wr_reg(A_ACK, 0, "R8 wack");
        rd_reg(A_INSRV, "R8 acked"); rd_reg(A_PEEK, "R8 destructive");
        wr_reg(A_EOI, 0, "R8 eoi");
        // R9 debug pin
        op(0, 0, A_PEND, 0, 8'h02, 0, "R9 raise src1");
        wr_reg(A_CTRL, 32'h4, "R9 enable");
        op(0, 0, A_PEND, 0, '0, 1, "R9 pin high");
        op(0, 0, A_PEND, 0, '0, 1, "R9 first edge");
        op(0, 0, A_PEND, 0, '0, 1, "R9 second edge");
        op(0, 0, A_PEND, 0, '0, 1, "R9 forced");
        wr_reg(A_CTRL, 32'h0, "R9 disable");
        op(0, 0, A_PEND, 0, '0, 1, "R9 ignored");
        op(0, 0, A_PEND, 0, '0, 0, "R9 pin low");

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            int sel = $urandom % 16;
            logic [N-1:0] irq = N'($urandom & $urandom & $urandom);
            logic dbg = ($urandom % 8) == 0;
            logic [31:0] rv = $urandom;
            case (sel)
                0, 1, 2, 3, 4: op(1, 0, A_ACK,   0, irq, dbg, "R2 rand ack");
                5, 6:          op(1, 0, A_PEEK,  0, irq, dbg, "R4 rand peek");
                7, 8, 9:       op(0, 1, A_EOI,   0, irq, dbg, "R7 rand eoi");
                10:            op(0, 1, A_MASK,  rv & $urandom & 32'hFF, irq, dbg, "R10 rand mask");
                11:            op(0, 1, A_CTRL,  rv & 32'h6 | ((rv[8] & rv[9]) ? 1 : 0), irq, dbg, "R8 rand ctrl");
                12:            op(0, 1, A_PRIO,  rv, irq, dbg, "R11 rand prio");
                13:            op(1, 0, A_PEND,  0, irq, dbg, "R13 rand pend");
                14:            op(1, 0, A_INSRV, 0, irq, dbg, "R6 rand insrv");
                default:       op(0, 1, A_ACK,   0, irq, dbg, "R8 rand wack");
            endcase
        end
        rd_reg(A_PRIO, "R11 final"); rd_reg(A_ID, "R12 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule